// File: doc/BRIEF.md
# Line Copy Directory with Reservations

This block is the coherence directory and data store of a small memory-side cache. It serves requests from up to eight first-level caches, each named by a source ID. For every line it records which sources hold a copy, and it keeps one reservation flag beside each recorded copy. Those flags implement linked-load / store-conditional atomics.

A linked load marks the requester's copy as reserved. If the requester held no copy, a reserved copy is created. A store-conditional writes only when the requester's copy is still reserved, and its boolean result comes back on the response channel.

Any successful store, whether a plain write or a winning store-conditional, does three things:
- It clears every reservation on the line.
- It pushes an UPDATE, one per cycle, to each other copy holder.
- It holds back its response until an acknowledgement has come back for every UPDATE.

Because reservations belong to a whole line, a store to any word of the line breaks every pending reservation on it.

Top module: `line_copy_dir`

## Requirements
- R1: A READ (`reqCmd`=2'b00) with `reqCached`=1 adds the requester to the copy set of the line `reqAddr[5:2]` and returns the whole line on `rspData`, with word w at bits [32w+31:32w].
- R2: A READ with `reqCached`=0 returns the addressed word (`reqAddr[1:0]`) in `rspData[31:0]` with all upper bits zero, and registers no copy: a later store by another source sends it no UPDATE.
- R3: A linked load (`reqCmd`=2'b10) returns the addressed word in `rspData[31:0]` and sets the requester's reservation on the line, creating its copy when none exists.
- R4: A store-conditional (`reqCmd`=2'b11) from a source whose copy is reserved writes `reqData`, clears all reservations of the line, sends UPDATE to every other copy holder, and answers `rspData`=1.
- R5: A store-conditional without a valid reservation answers `rspData`=0, writes nothing and sends no UPDATE.
- R6: A WRITE (`reqCmd`=2'b01) stores `reqData`, clears all reservations of the line, sends UPDATE to every copy holder except the writer, and answers `rspData`=0.
- R7: Reservations are per line: a WRITE to another word of a line makes a later store-conditional to that line fail.
- R8: UPDATEs go out one per cycle in ascending `updDst` order. Each carries the line, word and data of the store, and they appear only while a request is in progress.
- R9: `reqReady` drops after a request is accepted and returns only after its response. With k UPDATEs each acknowledged in the cycle it appears, `rspValid` is high in the cycle after the (k+1)-th clock edge following the accepting edge. Delayed acknowledgements delay the response to one cycle after the last one is counted.
- R10: After reset no source holds any copy or reservation, all data words are zero, `reqReady` is 1 and both `rspValid` and `updValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle; request taken on this edge when both high |
| reqCmd | input | 2 | 00 READ, 01 WRITE, 10 linked load, 11 store-conditional |
| reqCached | input | 1 | READ registers a copy and returns the whole line |
| reqSrc | input | 3 | Requesting source ID |
| reqAddr | input | 6 | Word address: [5:2] line, [1:0] word |
| reqData | input | 32 | Store data |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | 128 | Line, word, or store-conditional result in bit 0 |
| updValid | output | 1 | UPDATE request present |
| updDst | output | 3 | Source ID that receives the UPDATE |
| updLine | output | 4 | Line index of the store |
| updWord | output | 2 | Word index of the store |
| updData | output | 32 | Stored data |
| updAckValid | input | 1 | One UPDATE acknowledgement per high cycle |

## Verification
Every result lands a fixed number of edges after the accepting edge. An UPDATE becomes visible one edge after acceptance, and a following one appears after each further edge. The response follows k+1 edges after acceptance when every UPDATE is acknowledged at once, and two edges after the final acknowledgement is driven when acknowledgements are held back. The bench samples on falling edges and counts those samples from the accepting edge, so each latency is compared as an exact count. While acknowledgements are held back it also confirms, cycle by cycle, that no response or new acceptance appears.

// File: rtl/line_copy_dir_pkg.sv
package line_copy_dir_pkg;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_LL    = 2'b10,
    CMD_SC    = 2'b11
  } cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;       // latch request, capture response
    logic regCopy;    // add requester to copy set
    logic regResv;    // set requester's reservation
    logic storeWord;  // write reqData into the line
    logic wipeResv;   // clear all reservations of the line
    logic launchUpd;  // load UPDATE mask and ack counter
    logic issueOne;   // one UPDATE leaves this cycle
  } strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic scHit;
    logic pendAny;
    logic cntZero;
  } status_t;

endpackage

// File: rtl/line_copy_dir_dp.sv
module line_copy_dir_dp
  import line_copy_dir_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_SRC   = 8,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int WORD_W    = $clog2(WORDS),
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int ADDR_W    = LINE_W + WORD_W,
  localparam int LINE_BITS = WORDS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [1:0]           reqCmd,
  input  logic                 reqCached,
  input  logic [SRC_W-1:0]     reqSrc,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  input  logic                 updAckValid,
  output status_t              status,
  output logic [LINE_BITS-1:0] rspData,
  output logic [SRC_W-1:0]     updDst,
  output logic [LINE_W-1:0]    updLine,
  output logic [WORD_W-1:0]    updWord,
  output logic [DATA_W-1:0]    updData
);

  localparam int CNT_W = SRC_W + 1;

  logic [DATA_W-1:0]  mem     [NUM_LINES][WORDS];
  logic [NUM_SRC-1:0] copyVec [NUM_LINES];
  logic [NUM_SRC-1:0] resvVec [NUM_LINES];

  logic [LINE_W-1:0]    reqLine;
  logic [WORD_W-1:0]    reqWord;
  logic [NUM_SRC-1:0]   srcBit;
  logic [NUM_SRC-1:0]   targets;
  logic                 scHit;
  logic [LINE_BITS-1:0] lineFlat;
  logic [LINE_BITS-1:0] rspNext;

  logic [NUM_SRC-1:0]   pendMask;
  logic [CNT_W-1:0]     outCnt;
  logic [LINE_BITS-1:0] rspReg;
  logic [LINE_W-1:0]    opLine;
  logic [WORD_W-1:0]    opWord;
  logic [DATA_W-1:0]    opData;

  function automatic logic [CNT_W-1:0] countBits(input logic [NUM_SRC-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_SRC; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [SRC_W-1:0] lowIdx(input logic [NUM_SRC-1:0] v);
    logic [SRC_W-1:0] idx;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) if (v[i]) idx = SRC_W'(i);
    return idx;
  endfunction

  assign reqLine = reqAddr[ADDR_W-1:WORD_W];
  assign reqWord = reqAddr[WORD_W-1:0];
  assign srcBit  = NUM_SRC'(1) << reqSrc;
  assign scHit   = |(copyVec[reqLine] & resvVec[reqLine] & srcBit);
  assign targets = copyVec[reqLine] & ~srcBit;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_flat
      assign lineFlat[w*DATA_W +: DATA_W] = mem[reqLine][w];
    end
  endgenerate

  always_comb begin
    case (cmd_e'(reqCmd))
      CMD_READ:  rspNext = reqCached ? lineFlat : LINE_BITS'(mem[reqLine][reqWord]);
      CMD_LL:    rspNext = LINE_BITS'(mem[reqLine][reqWord]);
      CMD_SC:    rspNext = LINE_BITS'(scHit);
      default:   rspNext = '0;
    endcase
  end

  // Line storage and directory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        copyVec[l] <= '0;
        resvVec[l] <= '0;
        for (int w = 0; w < WORDS; w++) mem[l][w] <= '0;
      end
    end else begin
      if (st.storeWord) mem[reqLine][reqWord] <= reqData;
      if (st.regCopy)   copyVec[reqLine] <= copyVec[reqLine] | srcBit;
      if (st.wipeResv)  resvVec[reqLine] <= '0;
      else if (st.regResv) resvVec[reqLine] <= resvVec[reqLine] | srcBit;
    end
  end

  // Operation latch, UPDATE mask, acknowledgement counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
      outCnt   <= '0;
      rspReg   <= '0;
      opLine   <= '0;
      opWord   <= '0;
      opData   <= '0;
    end else begin
      if (st.take) begin
        rspReg <= rspNext;
        opLine <= reqLine;
        opWord <= reqWord;
        opData <= reqData;
      end
      if (st.launchUpd) begin
        pendMask <= targets;
        outCnt   <= countBits(targets);
      end else begin
        if (st.issueOne) pendMask <= pendMask & ~(NUM_SRC'(1) << lowIdx(pendMask));
        if (updAckValid && outCnt != '0) outCnt <= outCnt - CNT_W'(1);
      end
    end
  end

  assign status.scHit   = scHit;
  assign status.pendAny = |pendMask;
  assign status.cntZero = (outCnt == '0);

  assign rspData = rspReg;
  assign updDst  = lowIdx(pendMask);
  assign updLine = opLine;
  assign updWord = opWord;
  assign updData = opData;

endmodule

// File: rtl/line_copy_dir_ctrl.sv
module line_copy_dir_ctrl
  import line_copy_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqCmd,
  input  logic       reqCached,
  input  status_t    status,
  output logic       reqReady,
  output logic       rspValid,
  output logic       updValid,
  output strobe_t    st
);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_RESP} state_e;

  state_e state, stateNext;

  always_comb begin
    st = '0;
    st.take = (state == S_IDLE) && reqValid;
    if (st.take) begin
      case (cmd_e'(reqCmd))
        CMD_READ:  st.regCopy = reqCached;
        CMD_WRITE: begin
          st.storeWord = 1'b1;
          st.wipeResv  = 1'b1;
          st.launchUpd = 1'b1;
        end
        CMD_LL: begin
          st.regCopy = 1'b1;
          st.regResv = 1'b1;
        end
        CMD_SC: begin
          st.storeWord = status.scHit;
          st.wipeResv  = status.scHit;
          st.launchUpd = status.scHit;
        end
        default: ;
      endcase
    end
    st.issueOne = (state == S_BUSY) && status.pendAny;
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (reqValid) stateNext = S_BUSY;
      S_BUSY:  if (status.cntZero) stateNext = S_RESP;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign updValid = st.issueOne;

endmodule

// File: rtl/line_copy_dir.sv
module line_copy_dir
  import line_copy_dir_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_SRC   = 8,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int WORD_W    = $clog2(WORDS),
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int ADDR_W    = LINE_W + WORD_W,
  localparam int LINE_BITS = WORDS * DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqCmd,
  input  logic                 reqCached,
  input  logic [SRC_W-1:0]     reqSrc,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  output logic                 rspValid,
  output logic [LINE_BITS-1:0] rspData,
  output logic                 updValid,
  output logic [SRC_W-1:0]     updDst,
  output logic [LINE_W-1:0]    updLine,
  output logic [WORD_W-1:0]    updWord,
  output logic [DATA_W-1:0]    updData,
  input  logic                 updAckValid
);

  strobe_t st;
  status_t status;

  line_copy_dir_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCmd    (reqCmd),
    .reqCached (reqCached),
    .status    (status),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .updValid  (updValid),
    .st        (st)
  );

  line_copy_dir_dp #(
    .NUM_LINES (NUM_LINES),
    .WORDS     (WORDS),
    .DATA_W    (DATA_W),
    .NUM_SRC   (NUM_SRC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .reqCmd      (reqCmd),
    .reqCached   (reqCached),
    .reqSrc      (reqSrc),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .updAckValid (updAckValid),
    .status      (status),
    .rspData     (rspData),
    .updDst      (updDst),
    .updLine     (updLine),
    .updWord     (updWord),
    .updData     (updData)
  );

endmodule

// File: rtl/line_copy_dir_chk.sv
module line_copy_dir_chk #(
  parameter int DATA_W    = 32,
  parameter int LINE_BITS = 128,
  parameter int SRC_W     = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [1:0]           reqCmd,
  input logic                 reqCached,
  input logic                 rspValid,
  input logic [LINE_BITS-1:0] rspData,
  input logic                 updValid,
  input logic [SRC_W-1:0]     updDst
);

  logic [1:0] lastCmd;
  logic       lastCached;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCmd    <= 2'b00;
      lastCached <= 1'b0;
    end else if (reqValid && reqReady) begin
      lastCmd    <= reqCmd;
      lastCached <= reqCached;
    end
  end

  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9
  resp_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  // R8
  upd_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> (!reqReady && !rspValid));

  // R8
  upd_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && $past(updValid)) |-> (updDst > $past(updDst)));

  // R2
  uncached_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastCmd == 2'b00 && !lastCached) |-> ((rspData >> DATA_W) == '0));

  // R5
  sc_bool_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && lastCmd == 2'b11) |-> ((rspData >> 1) == '0));

endmodule

bind line_copy_dir line_copy_dir_chk u_chk (.*);

// File: tb/tb_line_copy_dir.sv
`timescale 1ns/1ps
module tb_line_copy_dir;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [1:0]   reqCmd = 2'b00;
  logic         reqCached = 1'b0;
  logic [2:0]   reqSrc = 3'd0;
  logic [5:0]   reqAddr = 6'd0;
  logic [31:0]  reqData = 32'd0;
  logic         rspValid;
  logic [127:0] rspData;
  logic         updValid;
  logic [2:0]   updDst;
  logic [3:0]   updLine;
  logic [1:0]   updWord;
  logic [31:0]  updData;
  logic         updAckValid = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_copy_dir dut (.*);

  // {cmd, cached, src, addr, data, expected rspData[31:0], expected UPDATE mask}
  localparam int NV = 22;
  localparam logic [83:0] VEC [NV] = '{
    {2'b01, 1'b0, 3'd0, 6'h04, 32'hA5A50001, 32'h0,        8'h00}, // 0  write, no holders
    {2'b00, 1'b0, 3'd1, 6'h04, 32'h0,        32'hA5A50001, 8'h00}, // 1  uncached read
    {2'b00, 1'b1, 3'd2, 6'h05, 32'h0,        32'hA5A50001, 8'h00}, // 2  cached read, word0 low
    {2'b10, 1'b0, 3'd3, 6'h04, 32'h0,        32'hA5A50001, 8'h00}, // 3  LL new copy
    {2'b11, 1'b0, 3'd3, 6'h04, 32'h1,        32'h1,        8'h04}, // 4  SC ok
    {2'b11, 1'b0, 3'd3, 6'h04, 32'h2,        32'h0,        8'h00}, // 5  SC again fails
    {2'b00, 1'b0, 3'd0, 6'h04, 32'h0,        32'h1,        8'h00}, // 6  failed SC left data
    {2'b10, 1'b0, 3'd5, 6'h06, 32'h0,        32'h0,        8'h00}, // 7  LL src5
    {2'b10, 1'b0, 3'd2, 6'h06, 32'h0,        32'h0,        8'h00}, // 8  LL src2 (has copy)
    {2'b01, 1'b0, 3'd1, 6'h07, 32'h77,       32'h0,        8'h2C}, // 9  write other word
    {2'b11, 1'b0, 3'd5, 6'h06, 32'h9,        32'h0,        8'h00}, // 10 false conflict
    {2'b00, 1'b0, 3'd4, 6'h06, 32'h0,        32'h0,        8'h00}, // 11 no write happened
    {2'b10, 1'b0, 3'd5, 6'h06, 32'h0,        32'h0,        8'h00}, // 12 LL again
    {2'b11, 1'b0, 3'd5, 6'h06, 32'h5555,     32'h1,        8'h0C}, // 13 SC ok, src0 not a holder
    {2'b00, 1'b0, 3'd7, 6'h06, 32'h0,        32'h5555,     8'h00}, // 14 read back
    {2'b11, 1'b0, 3'd7, 6'h20, 32'h3,        32'h0,        8'h00}, // 15 SC with no copy
    {2'b10, 1'b0, 3'd7, 6'h20, 32'h0,        32'h0,        8'h00}, // 16 LL creates copy
    {2'b01, 1'b0, 3'd7, 6'h20, 32'h42,       32'h0,        8'h00}, // 17 own write, no UPDATE
    {2'b11, 1'b0, 3'd7, 6'h20, 32'h5,        32'h0,        8'h00}, // 18 reservation cleared
    {2'b10, 1'b0, 3'd0, 6'h3F, 32'h0,        32'h0,        8'h00}, // 19 last line/word
    {2'b11, 1'b0, 3'd0, 6'h3F, 32'hDEAD,     32'h1,        8'h00}, // 20 SC ok, sole holder
    {2'b00, 1'b0, 3'd6, 6'h3F, 32'h0,        32'hDEAD,     8'h00}  // 21 read back
  };

  function automatic string tagOf(int idx, logic [1:0] cmd, logic cached, logic [31:0] expW);
    if (idx == 10) return "R7";
    if (idx == 11) return "R7";
    case (cmd)
      2'b00:   return cached ? "R1" : "R2";
      2'b01:   return "R6";
      2'b10:   return "R3";
      default: return (expW == 32'h1) ? "R4" : "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // One request with immediate acknowledgements. lat counts falling-edge samples after the accepting edge.
  task automatic runOp(input logic [1:0] cmd, input logic cached, input logic [2:0] src,
                       input logic [5:0] addr, input logic [31:0] data,
                       output logic [127:0] rdata, output logic [7:0] seen,
                       output int lat, output logic orderOk);
    int lastDst;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqCached = cached; reqSrc = src; reqAddr = addr; reqData = data;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    seen = '0; lat = 1; orderOk = 1'b1; lastDst = -1;
    while (!rspValid && lat < 60) begin
      if (updValid) begin
        if (int'(updDst) <= lastDst) orderOk = 1'b0;
        if (updData !== data || updLine !== addr[5:2] || updWord !== addr[1:0]) orderOk = 1'b0;
        lastDst = int'(updDst);
        seen[updDst] = 1'b1;
      end
      updAckValid = updValid;
      @(negedge clk);
      lat++;
    end
    updAckValid = 1'b0;
    rdata = rspData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] rd;
    logic [7:0]   seen;
    int           lat;
    logic         ok;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "reqReady after reset", 128'(reqReady), 128'(1));
    check("R10", "rspValid after reset", 128'(rspValid), 128'(0));
    check("R10", "updValid after reset", 128'(updValid), 128'(0));

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  vCmd;
      logic        vCached;
      logic [2:0]  vSrc;
      logic [5:0]  vAddr;
      logic [31:0] vData, vExp;
      logic [7:0]  vMask;
      string       tag;
      {vCmd, vCached, vSrc, vAddr, vData, vExp, vMask} = VEC[i];
      tag = tagOf(i, vCmd, vCached, vExp);
      runOp(vCmd, vCached, vSrc, vAddr, vData, rd, seen, lat, ok);
      check(tag, $sformatf("vec %0d response word", i), 128'(rd[31:0]), 128'(vExp));
      check("R8", $sformatf("vec %0d UPDATE set", i), 128'(seen), 128'(vMask));
      check("R8", $sformatf("vec %0d UPDATE order/fields", i), 128'(ok), 128'(1));
      // R9: k UPDATEs acked at once -> response at sample k+2
      check("R9", $sformatf("vec %0d latency", i), 128'(lat), 128'($countones(vMask) + 2));
    end

    // R1: full line of line 1 after the table
    runOp(2'b00, 1'b1, 3'd0, 6'h04, 32'h0, rd, seen, lat, ok);
    check("R1", "cached line contents", rd, {32'h77, 32'h5555, 32'h0, 32'h1});

    // R2: uncached read upper bits zero
    runOp(2'b00, 1'b0, 3'd1, 6'h07, 32'h0, rd, seen, lat, ok);
    check("R2", "uncached word only", rd, 128'h77);

    // R9 with held acknowledgements: holders of line 2 are 4 and 6
    runOp(2'b10, 1'b0, 3'd4, 6'h08, 32'h0, rd, seen, lat, ok);
    runOp(2'b00, 1'b1, 3'd6, 6'h09, 32'h0, rd, seen, lat, ok);
    @(negedge clk);
    reqValid = 1'b1; reqCmd = 2'b01; reqCached = 1'b0; reqSrc = 3'd4; reqAddr = 6'h0A; reqData = 32'hBEEF;
    @(posedge clk);
    @(negedge clk);
    // try to sneak a read in while busy
    reqCmd = 2'b00; reqSrc = 3'd1; reqAddr = 6'h0A; reqData = 32'h0;
    check("R8", "UPDATE valid", 128'(updValid), 128'(1));
    check("R8", "UPDATE dest", 128'(updDst), 128'(6));
    check("R8", "UPDATE fields", {updLine, updWord, updData}, 128'({4'd2, 2'd2, 32'hBEEF}));
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      check("R9", $sformatf("held cycle %0d no response", c), 128'(rspValid), 128'(0));
      check("R9", $sformatf("held cycle %0d not ready", c), 128'(reqReady), 128'(0));
      check("R8", $sformatf("held cycle %0d no UPDATE", c), 128'(updValid), 128'(0));
    end
    reqValid = 1'b0;
    updAckValid = 1'b1;
    @(negedge clk);
    updAckValid = 1'b0;
    check("R9", "one edge after ack", 128'(rspValid), 128'(0));
    @(negedge clk);
    check("R9", "two edges after ack", 128'(rspValid), 128'(1));
    check("R6", "write ack value", rspData, 128'(0));
    @(negedge clk);
    check("R9", "ready after response", 128'(reqReady), 128'(1));

    // R6: write landed, and the sneaked read had no effect on holders
    runOp(2'b00, 1'b0, 3'd2, 6'h0A, 32'h0, rd, seen, lat, ok);
    check("R6", "held write stored", rd, 128'hBEEF);
    // R2 / R6: writer 6 -> UPDATE to 4 only (1 never registered a copy)
    runOp(2'b01, 1'b0, 3'd6, 6'h08, 32'h11, rd, seen, lat, ok);
    check("R6", "UPDATE excludes writer and uncached readers", 128'(seen), 128'h10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule